// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-clock synchronous SRAM with a two-bit burst counter and a registered read path. The address and control inputs are captured on the rising clock edge. Read data is registered and appears one cycle after its address was captured. Words are split into byte lanes, and each lane can be written on its own. The bidirectional data bus is brought out as three ports: an input bus, an output bus and an output-drive enable.

An access starts on either of two address strobes. The strobe meant for a processor has priority over the strobe meant for a controller, and it is gated by the first chip select. A load cycle sets the upper address bits and the burst start. Each later cycle either steps the counter, when advance is low, or stays on the current word. The word order within a group of four is linear or interleaved, picked by a static input. The output enable and the sleep input act without waiting for a clock edge. While sleep is high, all accesses are ignored and the stored data is kept.

The default build has a reduced address width so that it elaborates quickly. The full 128K-word size is reached by setting `ADDR_W` to 17.

Top module: `burst_sram`

## Requirements
- R1: During and after synchronous reset, with no access issued, `rdata_oe` is 0 and `rdata` is all zeros.
- R2: A load cycle captures `addr` when either strobe is low. The word read at that address is on `rdata` after the second rising edge counted from the edge that captured it, which is one cycle after capture.
- R3: When both strobes are low in the same cycle, the processor strobe wins. A processor-strobe load is always a read: the write inputs are ignored and the addressed word is left unchanged.
- R4: While `sel1_n` is high, a low `proc_strobe_n` is ignored. With `ctrl_strobe_n` and `advance_n` high, such a cycle holds the current burst address.
- R5: The three chip selects are evaluated only on a load cycle, and the device is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load with any other combination deselects the device: nothing is written and `rdata_oe` stays 0. Changing the chip selects during a continuation cycle has no effect.
- R6: When `all_write_n` is low on a controller-strobe load or on a continuation cycle, every lane of the word is written, whatever `lane_write_en_n` and `lane_sel_n` show.
- R7: With `all_write_n` high and `lane_write_en_n` low, lane i (bits 9i+8 down to 9i) is written only if `lane_sel_n[i]` is 0. With both write inputs high, the cycle is a read.
- R8: With `burst_interleave`=0, each continuation cycle with `advance_n` low adds 1 to the two low address bits, wrapping modulo 4, and leaves the upper bits unchanged. This applies to reads and to writes.
- R9: With `burst_interleave`=1, the nth word of a burst (n = 0..3) is at low bits start XOR n.
- R10: A continuation cycle with both strobes high and `advance_n` high repeats the access at the current address.
- R11: `rdata_oe` is 1 only when the access in the previous cycle was a read. As a result, the first clock after leaving deselect does not drive, even with `out_en_n` low. Back-to-back reads drive on every cycle.
- R12: `out_en_n` high forces `rdata_oe` to 0 at once. `rdata` still updates, and the drive comes back as soon as `out_en_n` falls.
- R13: While `sleep` is high, no access is performed, the burst state is frozen and `rdata_oe` is 0. After sleep ends, the burst continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, captured on load cycles |
| proc_strobe_n | input | 1 | Processor address strobe, active low, high priority |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| advance_n | input | 1 | Step the burst counter, active low |
| all_write_n | input | 1 | Write all lanes, active low |
| lane_write_en_n | input | 1 | Enable lane-selective write, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous gate |
| burst_interleave | input | 1 | Static burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench first fills a small array with full-word writes and then reads it back as a pipelined stream that alternates between the two strobes. A model that lost the one-cycle read latency, or that drove the pins on the first clock after deselect, fails on the first sample. Other tests have both strobes low together with write inputs asserted, and a processor strobe arriving while chip select 1 is high. A design with the wrong priority or gating would corrupt the word or jump to the wrong address. The bench also sweeps each burst start in both orders, runs write bursts, and checks chip-select changes in the middle of a burst. Byte-select patterns and sleep in the middle of a burst expose a design that writes the wrong lanes, wraps into the upper address bits, or loses its place while asleep.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BURST_W = 2;

    typedef logic [BURST_W-1:0] burst_t;

    // Classification of one clock cycle as seen by the control path.
    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_PLOAD,
        CYC_CLOAD,
        CYC_DESEL,
        CYC_ADVANCE,
        CYC_HOLD,
        CYC_SLEEP
    } cyc_e;

    // Low address bits of the word at position `step` of a burst.
    function automatic burst_t burst_low(burst_t start, burst_t step, logic interleave);
        return interleave ? (start ^ step) : burst_t'(start + step);
    endfunction

    function automatic logic chip_selected(logic s1_n, logic s2, logic s3_n);
        return !s1_n && s2 && !s3_n;
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              advance_n,
    input  logic              all_write_n,
    input  logic              lane_write_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              sleep,
    input  logic              burst_interleave,
    output logic              acc_valid,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_wmask
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic            active_q;
    logic [HI_W-1:0] upper_q;
    burst_t          start_q;
    burst_t          step_q;
    burst_t          step_n;
    cyc_e            kind;
    logic            p_take;
    logic            sel_ok;
    logic            wr_req;
    logic [LANES-1:0] lanes;

    // Per-lane write decode: global write overrides lane selects.
    for (genvar i = 0; i < LANES; i++) begin : g_lane_dec
        assign lanes[i] = !all_write_n || (!lane_write_en_n && !lane_sel_n[i]);
    end
    assign wr_req = !all_write_n || !lane_write_en_n;

    // Strobe arbitration and cycle classification.
    always_comb begin
        p_take = !proc_strobe_n && !sel1_n;
        sel_ok = chip_selected(sel1_n, sel2, sel3_n);
        if (sleep)                kind = CYC_SLEEP;
        else if (p_take)          kind = sel_ok ? CYC_PLOAD : CYC_DESEL;
        else if (!ctrl_strobe_n)  kind = sel_ok ? CYC_CLOAD : CYC_DESEL;
        else if (!active_q)       kind = CYC_IDLE;
        else if (!advance_n)      kind = CYC_ADVANCE;
        else                      kind = CYC_HOLD;
    end

    // Access request for this cycle.
    always_comb begin
        step_n    = step_q;
        acc_valid = 1'b0;
        acc_wr    = 1'b0;
        acc_addr  = {upper_q, burst_low(start_q, step_q, burst_interleave)};
        acc_wmask = '0;
        unique case (kind)
            CYC_PLOAD: begin
                acc_valid = 1'b1;
                acc_addr  = addr;
            end
            CYC_CLOAD: begin
                acc_valid = 1'b1;
                acc_addr  = addr;
                acc_wr    = wr_req;
                acc_wmask = lanes;
            end
            CYC_ADVANCE, CYC_HOLD: begin
                if (kind == CYC_ADVANCE) step_n = step_q + burst_t'(1);
                acc_valid = 1'b1;
                acc_addr  = {upper_q, burst_low(start_q, step_n, burst_interleave)};
                acc_wr    = wr_req;
                acc_wmask = lanes;
            end
            default: ;
        endcase
    end

    // Burst state.
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            upper_q  <= '0;
            start_q  <= '0;
            step_q   <= '0;
        end else begin
            unique case (kind)
                CYC_PLOAD, CYC_CLOAD: begin
                    active_q <= 1'b1;
                    upper_q  <= addr[ADDR_W-1:BURST_W];
                    start_q  <= addr[BURST_W-1:0];
                    step_q   <= '0;
                end
                CYC_DESEL:   active_q <= 1'b0;
                CYC_ADVANCE: step_q   <= step_n;
                default: ;
            endcase
        end
    end

    // R3: processor-strobe load never writes.
    a_r3_proc_load_reads: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !proc_strobe_n && !sel1_n) |-> !acc_wr);

    // R4: gated processor strobe with no other request holds the burst.
    a_r4_gated_proc_holds: assert property (@(posedge clk) disable iff (rst)
        (!sleep && active_q && sel1_n && ctrl_strobe_n && advance_n)
        |=> ($stable(step_q) && $stable(upper_q) && $stable(start_q)));

    // R5: a controller load with chip select 2 low deselects.
    a_r5_bad_select_deselects: assert property (@(posedge clk) disable iff (rst)
        (!sleep && proc_strobe_n && !ctrl_strobe_n && !sel2) |=> !active_q);

    // R8: an advance step moves the counter by one.
    a_r8_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (!sleep && active_q && proc_strobe_n && ctrl_strobe_n && !advance_n)
        |=> (step_q == $past(step_q) + burst_t'(1)));

    // R13: sleep freezes the burst state.
    a_r13_sleep_freezes: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(active_q) && $stable(upper_q) && $stable(start_q) && $stable(step_q)));

endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= mem[addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    advance_n,
    input  logic                    all_write_n,
    input  logic                    lane_write_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic                    sleep,
    input  logic                    burst_interleave,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              valid;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  wmask;
        logic [DATA_W-1:0] wdata;
    } acc_t;

    acc_t              acc_d;
    acc_t              acc_q;
    logic              rd_valid_q;
    logic              c_valid;
    logic              c_wr;
    logic [ADDR_W-1:0] c_addr;
    logic [LANES-1:0]  c_wmask;

    bsram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .addr             (addr),
        .proc_strobe_n    (proc_strobe_n),
        .ctrl_strobe_n    (ctrl_strobe_n),
        .sel1_n           (sel1_n),
        .sel2             (sel2),
        .sel3_n           (sel3_n),
        .advance_n        (advance_n),
        .all_write_n      (all_write_n),
        .lane_write_en_n  (lane_write_en_n),
        .lane_sel_n       (lane_sel_n),
        .sleep            (sleep),
        .burst_interleave (burst_interleave),
        .acc_valid        (c_valid),
        .acc_wr           (c_wr),
        .acc_addr         (c_addr),
        .acc_wmask        (c_wmask)
    );

    always_comb begin
        acc_d.valid = c_valid;
        acc_d.wr    = c_wr;
        acc_d.addr  = c_addr;
        acc_d.wmask = c_wmask;
        acc_d.wdata = wdata;
    end

    // Capture stage: address, command and write data.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            acc_q      <= acc_d;
            rd_valid_q <= acc_q.valid && !acc_q.wr;
        end
    end

    // Array stage, one storage lane per byte lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bsram_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .addr  (acc_q.addr),
            .wr_en (acc_q.valid && acc_q.wr && acc_q.wmask[i]),
            .rd_en (acc_q.valid && !acc_q.wr),
            .wdata (acc_q.wdata[i*LANE_W +: LANE_W]),
            .rdata (rdata[i*LANE_W +: LANE_W])
        );
    end

    assign rdata_oe = rd_valid_q && !out_en_n && !sleep;

    // R11: the pins drive only with data from a read issued one cycle earlier.
    a_r11_drive_after_read: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> $past(acc_q.valid && !acc_q.wr));

    // R12: output enable high never lets the pins drive.
    a_r12_oe_blocks: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_oe);

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

    localparam int AW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          proc_n, ctrl_n, sel1_n, sel2, sel3_n, adv_n;
    logic          gw_n, bwe_n;
    logic [1:0]    bsel_n;
    logic          oe_n, sleep, il;
    logic [17:0]   wdata;
    logic [17:0]   rdata;
    logic          rdata_oe;

    logic [17:0]   model [N];
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) u_burst_sram (
        .clk(clk), .rst(rst), .addr(addr),
        .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .advance_n(adv_n), .all_write_n(gw_n), .lane_write_en_n(bwe_n),
        .lane_sel_n(bsel_n), .out_en_n(oe_n), .sleep(sleep),
        .burst_interleave(il), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [17:0] fill_val(int a);
        return 18'((a * 1237) ^ 18'h2A5C3);
    endfunction

    task automatic idle_in();
        proc_n = 1; ctrl_n = 1; sel1_n = 0; sel2 = 1; sel3_n = 0; adv_n = 1;
        gw_n = 1; bwe_n = 1; bsel_n = 2'b11; wdata = '0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic deselect();
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        idle_in(); cyc();
    endtask

    task automatic read_word(int a, string req);
        idle_in(); ctrl_n = 0; addr = AW'(a); cyc();
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        check(req, 32'(rdata), 32'(model[a]));
        check(req, 32'(rdata_oe), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; oe_n = 0; sleep = 0; il = 0; addr = '0;
        idle_in();
        repeat (3) cyc();
        check("R1", 32'(rdata_oe), 32'd0);
        check("R1", 32'(rdata), 32'd0);
        rst = 0;
        cyc();
        check("R1", 32'(rdata_oe), 32'd0);

        // R6: fill with global writes, lane inputs varying
        for (int a = 0; a < N; a++) begin
            idle_in(); ctrl_n = 0; addr = AW'(a); gw_n = 0;
            bwe_n = a[0]; bsel_n = 2'(a >> 1); wdata = fill_val(a);
            model[a] = fill_val(a);
            cyc();
        end
        deselect();

        // R2 / R11: pipelined read sweep, alternating strobes
        for (int i = 0; i <= N; i++) begin
            idle_in();
            if (i < N) begin
                addr = AW'(i);
                if (i % 2 == 0) proc_n = 0; else ctrl_n = 0;
            end else begin
                ctrl_n = 0; sel2 = 0;
            end
            cyc();
            if (i == 0) check("R11", 32'(rdata_oe), 32'd0);
            else begin
                check("R2", 32'(rdata), 32'(model[i-1]));
                check("R11", 32'(rdata_oe), 32'd1);
            end
        end
        idle_in(); cyc();
        check("R5", 32'(rdata_oe), 32'd0);

        // R7: lane-selective writes at 8..15
        for (int k = 0; k < 8; k++) begin
            int a = 8 + k;
            logic [17:0] d;
            d = ~model[a];
            idle_in(); ctrl_n = 0; addr = AW'(a);
            bwe_n = k[2]; bsel_n = 2'(k);
            wdata = d;
            if (!bwe_n) begin
                if (!bsel_n[0]) model[a][8:0]  = d[8:0];
                if (!bsel_n[1]) model[a][17:9] = d[17:9];
            end
            cyc();
        end
        deselect();
        for (int k = 0; k < 8; k++) read_word(8 + k, "R7");

        // R3: both strobes with write inputs -> read only
        idle_in(); proc_n = 0; ctrl_n = 0; gw_n = 0; addr = AW'(20); wdata = ~model[20];
        cyc();
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        check("R3", 32'(rdata), 32'(model[20]));
        check("R3", 32'(rdata_oe), 32'd1);
        read_word(20, "R3");

        // R4: gated processor strobe holds the burst
        idle_in(); ctrl_n = 0; addr = AW'(24); cyc();
        idle_in(); proc_n = 0; sel1_n = 1; addr = AW'(40); cyc();
        check("R4", 32'(rdata), 32'(model[24]));
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        check("R4", 32'(rdata), 32'(model[24]));

        // R5: selects ignored on continuation
        idle_in(); ctrl_n = 0; addr = AW'(28); cyc();
        idle_in(); adv_n = 0; sel1_n = 1; sel2 = 0; sel3_n = 1; cyc();
        check("R5", 32'(rdata), 32'(model[28]));
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        check("R5", 32'(rdata), 32'(model[29]));
        check("R5", 32'(rdata_oe), 32'd1);
        deselect();
        for (int k = 0; k < 3; k++) begin
            idle_in(); ctrl_n = 0; gw_n = 0; addr = AW'(30); wdata = ~model[30];
            if (k == 0) sel1_n = 1;
            if (k == 1) sel2 = 0;
            if (k == 2) sel3_n = 1;
            cyc();
            idle_in(); cyc();
            check("R5", 32'(rdata_oe), 32'd0);
        end
        read_word(30, "R5");

        // R8 linear and R9 interleaved read bursts, every start
        for (int mode = 0; mode < 2; mode++) begin
            for (int s = 0; s < 4; s++) begin
                int base = (mode == 0) ? 32 : 36;
                il = mode[0];
                idle_in(); ctrl_n = 0; addr = AW'(base + s); cyc();
                for (int j = 1; j <= 5; j++) begin
                    int low;
                    idle_in();
                    if (j <= 4) adv_n = 0; else begin ctrl_n = 0; sel2 = 0; end
                    cyc();
                    low = (mode == 0) ? ((s + j - 1) & 3) : (s ^ ((j - 1) & 3));
                    check(mode == 0 ? "R8" : "R9", 32'(rdata), 32'(model[base + low]));
                end
            end
        end
        il = 0;

        // R8: linear write burst starting at low bits 2
        idle_in(); ctrl_n = 0; gw_n = 0; addr = AW'(46); wdata = 18'h11111; model[46] = 18'h11111; cyc();
        idle_in(); adv_n = 0; gw_n = 0; wdata = 18'h22222; model[47] = 18'h22222; cyc();
        idle_in(); adv_n = 0; gw_n = 0; wdata = 18'h33333; model[44] = 18'h33333; cyc();
        deselect();
        read_word(44, "R8"); read_word(46, "R8"); read_word(47, "R8"); read_word(45, "R8");

        // R10: hold repeats the address
        idle_in(); ctrl_n = 0; addr = AW'(50); cyc();
        for (int j = 0; j < 3; j++) begin
            idle_in(); cyc();
            check("R10", 32'(rdata), 32'(model[50]));
        end
        deselect();

        // R12: output enable gating
        idle_in(); ctrl_n = 0; addr = AW'(52); oe_n = 1; cyc();
        idle_in(); cyc();
        check("R12", 32'(rdata_oe), 32'd0);
        check("R12", 32'(rdata), 32'(model[52]));
        oe_n = 0; #1;
        check("R12", 32'(rdata_oe), 32'd1);
        deselect();

        // R13: sleep mid-burst
        idle_in(); ctrl_n = 0; addr = AW'(56); cyc();
        idle_in(); sleep = 1; ctrl_n = 0; gw_n = 0; addr = AW'(60); wdata = ~model[60]; cyc();
        check("R13", 32'(rdata_oe), 32'd0);
        check("R13", 32'(rdata), 32'(model[56]));
        cyc();
        check("R13", 32'(rdata_oe), 32'd0);
        sleep = 0; idle_in(); adv_n = 0; cyc();
        idle_in(); ctrl_n = 0; sel2 = 0; cyc();
        check("R13", 32'(rdata), 32'(model[57]));
        read_word(60, "R13");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule